// File: doc/BRIEF.md
# Eight-Bit ALU with Registered Status Flags

This block is a small arithmetic and logic unit for an eight-bit datapath. Two operands and a two-bit operation code produce a result with no clock in the path. That result drives a set of status flags held in a register: carry, zero, negative, overflow and sign-test. The flags are captured on a rising clock edge only while the update strobe is high. When the strobe is low the flags keep their values. This lets a sequencer compute a value without disturbing the condition codes.

Four operations are supported: addition and the three bitwise operations AND, OR and exclusive OR. For addition, the overflow flag reports a two's complement overflow and carry reports the carry out of the top bit. A bitwise operation cannot lose information, so it always clears overflow. Bitwise operations also leave carry as it was. The sign-test flag is always negative XOR overflow, so after a bitwise operation it equals the negative flag.

Top module: `alu8_core`

## Requirements
- R1: `result_o` follows the operands with no clock: op code 2'b00 gives `a_i + b_i` modulo 256, 2'b01 gives `a_i & b_i`, 2'b10 gives `a_i | b_i`, and 2'b11 gives `a_i ^ b_i`.
- R2: On an update edge, `z_o` becomes 1 exactly when the result is 0x00. This holds for every operation.
- R3: On an update edge, `n_o` takes bit 7 of the result.
- R4: `s_o` always equals `n_o ^ v_o`.
- R5: On an ADD update, `v_o` is set exactly when both operands have the same bit 7 and the result's bit 7 differs from it.
- R6: On an AND, OR or EOR update, `v_o` is cleared. As a result, `s_o` equals `n_o`.
- R7: On an ADD update, `c_o` takes the carry out of bit 7.
- R8: An AND, OR or EOR update leaves `c_o` unchanged.
- R9: When `flag_we_i` is low, no flag changes at the clock edge, whatever the inputs are.
- R10: While `rst_ni` is low, all five flags are 0, without waiting for a clock edge.
- R11: ADD of 0x80 and 0x80 gives result 0x00 with C, Z, V and S set and N clear.
- R12: EOR of 0x80 with 0x80 gives 0x00 with Z set and N, V and S clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| op_i | input | 2 | Operation code: 00 ADD, 01 AND, 10 OR, 11 EOR |
| flag_we_i | input | 1 | Flag update strobe |
| result_o | output | 8 | Combinational result |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| s_o | output | 1 | Sign-test flag (N xor V) |

## Verification
The hardest state to reach is a bitwise operation that follows an addition which left carry or overflow set. Only then does a wrong clear of V or a wrong update of C show up. Starting from reset, every flag is already zero, so those faults stay hidden. The stimulus therefore chains directed pairs: an ADD that overflows or carries, then AND, OR or EOR updates whose results are negative or zero. A strobe-low cycle with different operands sits between them to show that the flags hold. A swept sequence of operand pairs then mixes all four operations with the strobe sometimes low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_EOR = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic s;
  } alu_flags_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  always_comb begin
    full    = {1'b0, a_i} + {1'b0, b_i};
    sum_o   = full[MSB:0];
    carry_o = full[WIDTH];
    // same-sign operands, result sign flipped
    ovf_o   = (a_i[MSB] & b_i[MSB] & ~full[MSB]) | (~a_i[MSB] & ~b_i[MSB] & full[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (op_i)
        OP_AND:  res_o[i] = a_i[i] & b_i[i];
        OP_OR:   res_o[i] = a_i[i] | b_i[i];
        OP_EOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             is_arith_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  output alu_flags_t       flags_o
);
  localparam int MSB = WIDTH - 1;

  alu_flags_t flags_q, flags_d;

  always_comb begin
    flags_d.z = ~|result_i;
    flags_d.n = result_i[MSB];
    flags_d.v = is_arith_i & ovf_i;
    flags_d.c = is_arith_i ? carry_i : flags_q.c;
    flags_d.s = flags_d.n ^ flags_d.v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] result_o,
  output logic             c_o,
  output logic             z_o,
  output logic             n_o,
  output logic             v_o,
  output logic             s_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] sum, lres;
  logic             carry, ovf, is_arith;
  alu_flags_t       flags;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD);

  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i(a_i), .b_i(b_i), .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(lres)
  );

  assign result_o = is_arith ? sum : lres;

  alu8_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we_i), .is_arith_i(is_arith),
    .result_i(result_o), .carry_i(carry), .ovf_i(ovf), .flags_o(flags)
  );

  assign c_o = flags.c;
  assign z_o = flags.z;
  assign n_o = flags.n;
  assign v_o = flags.v;
  assign s_o = flags.s;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             flag_we_i,
  input logic [WIDTH-1:0] result_o,
  input logic             c_o,
  input logic             z_o,
  input logic             n_o,
  input logic             v_o,
  input logic             s_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] add_full;
  logic           add_ovf;
  assign add_full = {1'b0, a_i} + {1'b0, b_i};
  assign add_ovf  = (a_i[MSB] == b_i[MSB]) && (add_full[MSB] != a_i[MSB]);

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |-> result_o == add_full[MSB:0]); // R1
  AST_AND_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |-> result_o == (a_i & b_i)); // R1
  AST_OR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |-> result_o == (a_i | b_i)); // R1
  AST_EOR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |-> result_o == (a_i ^ b_i)); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> z_o == ($past(result_o) == '0)); // R2
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> n_o == $past(result_o[MSB])); // R3
  AST_SIGN_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_o == (n_o ^ v_o)); // R4
  AST_ADD_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i == 2'b00 |=> v_o == $past(add_ovf)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i != 2'b00 |=> !v_o); // R6
  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i == 2'b00 |=> c_o == $past(add_full[WIDTH])); // R7
  AST_CARRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i != 2'b00 |=> $stable(c_o)); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable({c_o, z_o, n_o, v_o, s_o})); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> {c_o, z_o, n_o, v_o, s_o} == 5'b0); // R10
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  typedef struct {
    logic [7:0] res;
    logic [4:0] flg;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] a_i, b_i;
  logic [1:0] op_i;
  logic       flag_we_i;
  logic [7:0] result_o;
  logic       c_o, z_o, n_o, v_o, s_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  exp_t q[$];
  logic [4:0] mf;  // model flags {c,z,n,v,s}

  always #10 clk_i = ~clk_i;

  alu8_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .flag_we_i(flag_we_i), .result_o(result_o),
    .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o), .s_o(s_o)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: drives inputs at the falling edge and queues the expected outcome
  task automatic apply(logic [7:0] a, logic [7:0] b, logic [1:0] op, logic we, string tag);
    logic [8:0] full;
    logic [7:0] r;
    logic       c, z, n, v;
    exp_t       e;
    @(negedge clk_i);
    a_i = a; b_i = b; op_i = op; flag_we_i = we;
    full = {1'b0, a} + {1'b0, b};
    c = mf[4];
    v = 1'b0;
    case (op)
      2'b00: begin
        r = full[7:0]; c = full[8];
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      2'b01: r = a & b;
      2'b10: r = a | b;
      default: r = a ^ b;
    endcase
    z = (r == 8'h00);
    n = r[7];
    if (we) mf = {c, z, n, v, n ^ v};
    e.res = r; e.flg = mf; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares just after the edge that updates the flags
  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "result", result_o, e.res);
        check(e.tag, "flags{c,z,n,v,s}", {3'b0, c_o, z_o, n_o, v_o, s_o}, {3'b0, e.flg});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_ni = 1'b1;
    a_i = '0; b_i = '0; op_i = '0; flag_we_i = 1'b0;
    mf = '0;
    #2 rst_ni = 1'b0;
    #3;
    check("R10", "flags in reset", {3'b0, c_o, z_o, n_o, v_o, s_o}, 8'h00);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11: 0x80 + 0x80
    apply(8'h80, 8'h80, 2'b00, 1'b1, "R11");
    // R9: strobe low, different operands
    apply(8'h01, 8'h02, 2'b10, 1'b0, "R9");
    // R12 and R6: EOR after overflow, V and C effects
    apply(8'h80, 8'h80, 2'b11, 1'b1, "R12/R6/R8");
    // R5: positive overflow, no carry
    apply(8'h40, 8'h40, 2'b00, 1'b1, "R5/R7");
    // R6 and R4: negative AND after overflow gives S = N
    apply(8'hF0, 8'h80, 2'b01, 1'b1, "R6/R4");
    // R7: carry with zero result
    apply(8'hFF, 8'h01, 2'b00, 1'b1, "R7/R2");
    // R8: OR keeps carry
    apply(8'h01, 8'h80, 2'b10, 1'b1, "R8/R3");
    // R8: AND to zero keeps carry
    apply(8'h0F, 8'hF0, 2'b01, 1'b1, "R8/R2");
    // R5: negative overflow with carry
    apply(8'h90, 8'hA0, 2'b00, 1'b1, "R5/R7");
    // R9: strobe low with an ADD that would change everything
    apply(8'h00, 8'h00, 2'b00, 1'b0, "R9");
    // R1 sweep with mixed strobes
    for (int i = 0; i < 200; i++) begin
      apply(8'(i * 37 + 5), 8'(i * 91 + 3), 2'(i % 4), (i % 5) != 0, "R1/R2/R3/R4/R5/R7");
    end
    // R10: asynchronous reset clears flags set before
    apply(8'hFF, 8'h81, 2'b00, 1'b1, "R5/R7");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R10", "flags after async reset", {3'b0, c_o, z_o, n_o, v_o, s_o}, 8'h00);
    mf = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(8'h7F, 8'h01, 2'b00, 1'b1, "R5/R3");
    @(posedge clk_i);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule